// File: doc/BRIEF.md
# Fully Associative Micro Translation Cache

This block is a small fully associative store of address translations placed ahead of a larger, less associative main translation buffer. A lookup gives a virtual page number and an address-space identifier (ASID). When a stored translation matches, the physical page number and its attribute bits come back combinationally in the same cycle. When nothing matches, the block raises a refill request toward the main buffer. It installs the returned descriptor and then accepts lookups again. A design instantiates it twice: eight entries on the data side and four on the instruction side, using the `ENTRIES` parameter.

The stored entries are independent of the main buffer. A main-buffer entry being replaced by a victim choice does not reach this block, and neither does a main-buffer write issued without invalidation. Both leave every entry in place. This lets the wider associativity here hide conflict misses in the main buffer. The only way to remove entries is the invalidate input, which clears all of them at once. The main buffer's command logic drives it on an ordinary write or on an explicit invalidate command.

Top module: `micro_tlb`

## Requirements
- R1: A lookup with `lk_valid` high, while no refill is pending, hits in the same cycle when a valid entry holds the same page number and the same ASID. `lk_pfn` and `lk_attr` then carry that entry's data. When there is no hit, both are zero.
- R2: An entry whose page number matches but whose ASID differs does not hit. An entry whose ASID matches but whose page number differs does not hit either.
- R3: A lookup that misses while no refill is pending raises `fill_req` from the next cycle. The block presents the missing page number and ASID on `fill_vpn` and `fill_asid`, and keeps all three steady until `fill_valid` is seen.
- R4: Only one refill is outstanding at a time. While `fill_req` is high, `lk_ready` and `lk_hit` are low and new lookups are stalled.
- R5: A `fill_valid` pulse while `fill_req` is high installs the descriptor for the pending page number and ASID, and drops `fill_req` in the next cycle. A later lookup of that pair hits with the returned data.
- R6: The install slot is the lowest-numbered invalid entry. When every entry is valid, a rotating pointer picks the slot. The pointer starts at 0 after reset, advances by one (wrapping) each time it is used, and is not moved by invalidation.
- R7: A one-cycle pulse on `inval` clears every entry, so any lookup in the following cycles misses until refills occur.
- R8: If `inval` is high in the cycle of the refill response, the response is discarded. The same happens if `inval` is high at any point from the miss cycle onward while the refill is pending. In both cases `fill_req` still falls and a later lookup of that pair misses.
- R9: A `fill_valid` pulse while no refill is pending is ignored and installs nothing.
- R10: Apart from installs and `inval`, entries never change. They stay valid across any number of idle cycles, so activity in the main buffer, such as victim replacement or writes without invalidation, has no effect here.
- R11: After synchronous reset, every entry is invalid, `fill_req` is low and `lk_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_asid | input | 8 | Lookup address-space identifier |
| lk_ready | output | 1 | High when lookups are accepted (no refill pending) |
| lk_hit | output | 1 | Same-cycle hit indication |
| lk_pfn | output | 20 | Physical page number on hit |
| lk_attr | output | 6 | Attribute bits on hit |
| fill_req | output | 1 | Refill request to the main buffer |
| fill_vpn | output | 20 | Page number being refilled |
| fill_asid | output | 8 | ASID being refilled |
| fill_valid | input | 1 | Refill response present |
| fill_pfn | input | 20 | Refill physical page number |
| fill_attr | input | 6 | Refill attribute bits |
| inval | input | 1 | Clear all entries |

## Verification
Some properties are checked on every cycle: at most one entry matches any lookup, a miss always starts a refill, and the refill request and its page/ASID stay steady until answered. Lookups stay stalled while a refill is pending, and no hit can occur in the cycle after an invalidate. Other behaviour appears only through the bench's lookup sequences: slot choice (first invalid, then the rotating pointer), survival of entries across long idle stretches, and the discarded response when invalidation meets a pending or returning refill. Whether a stray response installs anything is also visible only there.

// File: rtl/mtlb_pkg.sv
package mtlb_pkg;

    localparam int VPN_W  = 20;
    localparam int ASID_W = 8;
    localparam int PFN_W  = 20;
    localparam int ATTR_W = 6;

    // Tag half of an entry: presence bit plus the match key
    typedef struct packed {
        logic              live;
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
    } xl_tag_t;

    // Data half of an entry: what a hit returns
    typedef struct packed {
        logic [PFN_W-1:0]  pfn;
        logic [ATTR_W-1:0] attr;
    } xl_data_t;

    typedef enum logic {
        FILL_IDLE = 1'b0,
        FILL_WAIT = 1'b1
    } fill_state_e;

    function automatic logic tag_match(input xl_tag_t t,
                                       input logic [VPN_W-1:0] v,
                                       input logic [ASID_W-1:0] a);
        return t.live && (t.vpn == v) && (t.asid == a);
    endfunction

    function automatic int unsigned slot_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/mtlb_match.sv
module mtlb_match
    import mtlb_pkg::*;
#(
    parameter int N = 8
) (
    input  xl_tag_t            tags [N],
    input  logic [VPN_W-1:0]   vpn,
    input  logic [ASID_W-1:0]  asid,
    output logic [N-1:0]       hit_vec
);

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = tag_match(tags[g], vpn, asid);
    end

endmodule

// File: rtl/mtlb_victim.sv
module mtlb_victim #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  live_vec,
    input  logic          take,
    output logic [IW-1:0] slot
);

    localparam logic [IW-1:0] LAST = IW'(N - 1);

    logic [IW-1:0] rr_q;
    logic [IW-1:0] free_idx;
    logic          all_live;

    assign all_live = &live_vec;

    // Scan from the top so the lowest invalid index is the one kept
    always_comb begin
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!live_vec[i]) free_idx = IW'(i);
        end
    end

    assign slot = all_live ? rr_q : free_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_q <= '0;
        end else if (take && all_live) begin
            rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
        end
    end

endmodule

// File: rtl/mtlb_fill_ctl.sv
module mtlb_fill_ctl
    import mtlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic [VPN_W-1:0]  miss_vpn,
    input  logic [ASID_W-1:0] miss_asid,
    input  logic              resp_valid,
    input  logic              flush,
    output logic              waiting,
    output logic              install,
    output logic [VPN_W-1:0]  pend_vpn,
    output logic [ASID_W-1:0] pend_asid
);

    fill_state_e state_q;
    logic        drop_q;

    assign waiting = (state_q == FILL_WAIT);
    assign install = waiting && resp_valid && !drop_q && !flush;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= FILL_IDLE;
            drop_q    <= 1'b0;
            pend_vpn  <= '0;
            pend_asid <= '0;
        end else begin
            case (state_q)
                FILL_IDLE: begin
                    if (launch) begin
                        state_q   <= FILL_WAIT;
                        pend_vpn  <= miss_vpn;
                        pend_asid <= miss_asid;
                        drop_q    <= flush;
                    end
                end
                FILL_WAIT: begin
                    if (resp_valid) begin
                        state_q <= FILL_IDLE;
                        drop_q  <= 1'b0;
                    end else if (flush) begin
                        drop_q  <= 1'b1;
                    end
                end
                default: state_q <= FILL_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/micro_tlb.sv
module micro_tlb
    import mtlb_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              lk_ready,
    output logic              lk_hit,
    output logic [PFN_W-1:0]  lk_pfn,
    output logic [ATTR_W-1:0] lk_attr,
    output logic              fill_req,
    output logic [VPN_W-1:0]  fill_vpn,
    output logic [ASID_W-1:0] fill_asid,
    input  logic              fill_valid,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic [ATTR_W-1:0] fill_attr,
    input  logic              inval
);

    localparam int IW = slot_width(ENTRIES);

    xl_tag_t              tags [ENTRIES];
    xl_data_t             data [ENTRIES];
    logic [ENTRIES-1:0]   live_vec;
    logic [ENTRIES-1:0]   hit_vec;
    logic                 any_match;
    logic                 waiting;
    logic                 install;
    logic                 launch;
    logic [IW-1:0]        slot;
    xl_data_t             sel_data;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_live
        assign live_vec[g] = tags[g].live;
    end

    mtlb_match #(.N(ENTRIES)) u_match (
        .tags    (tags),
        .vpn     (lk_vpn),
        .asid    (lk_asid),
        .hit_vec (hit_vec)
    );

    assign any_match = |hit_vec;
    assign lk_ready  = !waiting;
    assign lk_hit    = lk_valid && !waiting && any_match;
    assign launch    = lk_valid && !waiting && !any_match;
    assign fill_req  = waiting;

    // One-hot OR mux over matching entries
    always_comb begin
        sel_data = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) sel_data = xl_data_t'(sel_data | data[i]);
        end
    end

    assign lk_pfn  = lk_hit ? sel_data.pfn  : '0;
    assign lk_attr = lk_hit ? sel_data.attr : '0;

    mtlb_fill_ctl u_fill (
        .clk        (clk),
        .rst        (rst),
        .launch     (launch),
        .miss_vpn   (lk_vpn),
        .miss_asid  (lk_asid),
        .resp_valid (fill_valid),
        .flush      (inval),
        .waiting    (waiting),
        .install    (install),
        .pend_vpn   (fill_vpn),
        .pend_asid  (fill_asid)
    );

    mtlb_victim #(.N(ENTRIES), .IW(IW)) u_victim (
        .clk      (clk),
        .rst      (rst),
        .live_vec (live_vec),
        .take     (install),
        .slot     (slot)
    );

    // Entry storage: invalidate wins over a same-cycle install
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                tags[i] <= '0;
                data[i] <= '0;
            end
        end else if (inval) begin
            for (int i = 0; i < ENTRIES; i++) begin
                tags[i].live <= 1'b0;
            end
        end else if (install) begin
            tags[slot] <= '{live: 1'b1, vpn: fill_vpn, asid: fill_asid};
            data[slot] <= '{pfn: fill_pfn, attr: fill_attr};
        end
    end

endmodule

// File: rtl/micro_tlb_chk.sv
module micro_tlb_chk
    import mtlb_pkg::*;
#(
    parameter int N = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              lk_valid,
    input logic              lk_ready,
    input logic              lk_hit,
    input logic              fill_req,
    input logic [VPN_W-1:0]  fill_vpn,
    input logic [ASID_W-1:0] fill_asid,
    input logic              fill_valid,
    input logic              inval,
    input logic [N-1:0]      hit_vec
);

    // R5: installs only follow misses, so no key is ever stored twice
    assert_single_match_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    assert_miss_starts_fill_R3: assert property (@(posedge clk) disable iff (rst)
        lk_valid && lk_ready && !lk_hit |=> fill_req);

    assert_fill_steady_R3: assert property (@(posedge clk) disable iff (rst)
        fill_req && !fill_valid |=> fill_req && $stable(fill_vpn) && $stable(fill_asid));

    assert_stall_R4: assert property (@(posedge clk) disable iff (rst)
        fill_req |-> !lk_ready && !lk_hit);

    assert_fill_ends_R8: assert property (@(posedge clk) disable iff (rst)
        fill_req && fill_valid |=> !fill_req);

    assert_flush_empties_R7: assert property (@(posedge clk) disable iff (rst)
        inval |=> !lk_hit);

    assert_stray_response_R9: assert property (@(posedge clk) disable iff (rst)
        !fill_req && fill_valid && !lk_valid |=> !fill_req);

endmodule

bind micro_tlb micro_tlb_chk #(.N(ENTRIES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .lk_valid   (lk_valid),
    .lk_ready   (lk_ready),
    .lk_hit     (lk_hit),
    .fill_req   (fill_req),
    .fill_vpn   (fill_vpn),
    .fill_asid  (fill_asid),
    .fill_valid (fill_valid),
    .inval      (inval),
    .hit_vec    (hit_vec)
);

// File: tb/tb_micro_tlb.sv
module tb_micro_tlb;
    import mtlb_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              lk_valid = 1'b0;
    logic [VPN_W-1:0]  lk_vpn = '0;
    logic [ASID_W-1:0] lk_asid = '0;
    logic              lk_ready, lk_hit;
    logic [PFN_W-1:0]  lk_pfn;
    logic [ATTR_W-1:0] lk_attr;
    logic              fill_req;
    logic [VPN_W-1:0]  fill_vpn;
    logic [ASID_W-1:0] fill_asid;
    logic              fill_valid = 1'b0;
    logic [PFN_W-1:0]  fill_pfn = '0;
    logic [ATTR_W-1:0] fill_attr = '0;
    logic              inval = 1'b0;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    micro_tlb #(.ENTRIES(8)) dut (.*);

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic              hit;
    } vec_t;

    // Expected hit column follows R2 (key match) and R6 (slot choice, 8 entries)
    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{20'h10, 8'd1, 1'b0}, '{20'h10, 8'd1, 1'b1}, '{20'h10, 8'd2, 1'b0},
        '{20'h11, 8'd1, 1'b0}, '{20'h10, 8'd2, 1'b1}, '{20'h20, 8'd3, 1'b0},
        '{20'h21, 8'd3, 1'b0}, '{20'h22, 8'd3, 1'b0}, '{20'h23, 8'd3, 1'b0},
        '{20'h24, 8'd3, 1'b0}, '{20'h11, 8'd1, 1'b1}, '{20'h30, 8'd3, 1'b0},
        '{20'h10, 8'd1, 1'b0}, '{20'h10, 8'd2, 1'b0}, '{20'h30, 8'd3, 1'b1},
        '{20'h11, 8'd1, 1'b0}, '{20'h21, 8'd3, 1'b1}, '{20'h20, 8'd3, 1'b0},
        '{20'h21, 8'd3, 1'b0}, '{20'h23, 8'd3, 1'b1}
    };

    function automatic logic [PFN_W-1:0] mk_pfn(logic [VPN_W-1:0] v, logic [ASID_W-1:0] a);
        return v ^ {a, 12'h000} ^ 20'h5A5A5;
    endfunction

    function automatic logic [ATTR_W-1:0] mk_attr(logic [VPN_W-1:0] v, logic [ASID_W-1:0] a);
        return v[ATTR_W-1:0] ^ a[ATTR_W-1:0] ^ 6'h15;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    logic              s_hit, s_rdy;
    logic [PFN_W-1:0]  s_pfn;
    logic [ATTR_W-1:0] s_attr;

    // Present one lookup for one clock; returns at the following negedge
    task automatic lookup(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a);
        @(negedge clk);
        lk_valid = 1'b1; lk_vpn = v; lk_asid = a;
        #1;
        s_hit = lk_hit; s_rdy = lk_ready; s_pfn = lk_pfn; s_attr = lk_attr;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    // mode 0: plain response; 1: inval with response; 2: inval while pending
    task automatic serve(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a, input int mode);
        chk(fill_req === 1'b1, "R3", "fill_req after miss", 32'(fill_req), 1);
        chk(fill_vpn === v && fill_asid === a, "R3", "refill key",
            {4'h0, fill_vpn, fill_asid}, {4'h0, v, a});
        lk_valid = 1'b1; lk_vpn = v; lk_asid = a;
        #1;
        chk(lk_ready === 1'b0 && lk_hit === 1'b0, "R4", "stall while pending",
            {lk_ready, lk_hit}, 0);
        @(negedge clk);
        chk(fill_req === 1'b1, "R3", "fill_req held", 32'(fill_req), 1);
        if (mode == 2) inval = 1'b1;
        @(negedge clk);
        inval = 1'b0; lk_valid = 1'b0;
        fill_valid = 1'b1; fill_pfn = mk_pfn(v, a); fill_attr = mk_attr(v, a);
        if (mode == 1) inval = 1'b1;
        @(negedge clk);
        fill_valid = 1'b0; inval = 1'b0;
        chk(fill_req === 1'b0 && lk_ready === 1'b1, "R8", "refill closes",
            {fill_req, lk_ready}, 1);
    endtask

    task automatic expect_hit(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a, input string req);
        lookup(v, a);
        chk(s_hit === 1'b1, req, "expected hit", 32'(s_hit), 1);
        chk(s_pfn === mk_pfn(v, a) && s_attr === mk_attr(v, a), "R1", "hit data",
            {6'h0, s_pfn, s_attr}, {6'h0, mk_pfn(v, a), mk_attr(v, a)});
    endtask

    task automatic expect_miss_fill(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a,
                                    input string req, input int mode);
        lookup(v, a);
        chk(s_hit === 1'b0 && s_pfn === '0, req, "expected miss", {s_hit, 11'h0, s_pfn}, 0);
        serve(v, a, mode);
    endtask

    initial begin
        // R11: reset state
        repeat (3) @(negedge clk);
        lk_valid = 1'b1; lk_vpn = '0; lk_asid = '0;
        #1;
        chk(lk_hit === 1'b0 && lk_ready === 1'b1 && fill_req === 1'b0, "R11",
            "reset outputs", {lk_hit, lk_ready, fill_req}, 3'b010);
        @(negedge clk);
        lk_valid = 1'b0; rst = 1'b0;

        // Table walk: R1, R2, R5, R6
        for (int i = 0; i < NV; i++) begin
            lookup(VECS[i].vpn, VECS[i].asid);
            chk(s_hit === VECS[i].hit, "R2", "table hit/miss (R6 slot order)",
                32'(s_hit), 32'(VECS[i].hit));
            if (s_hit === 1'b1) begin
                chk(s_pfn === mk_pfn(VECS[i].vpn, VECS[i].asid), "R1", "table pfn",
                    32'(s_pfn), 32'(mk_pfn(VECS[i].vpn, VECS[i].asid)));
            end else if (s_hit === 1'b0) begin
                serve(VECS[i].vpn, VECS[i].asid, 0);
                expect_hit(VECS[i].vpn, VECS[i].asid, "R5");
            end
        end

        // R10: entries persist over a long idle stretch
        repeat (60) @(negedge clk);
        expect_hit(20'h23, 8'd3, "R10");
        expect_hit(20'h30, 8'd3, "R10");

        // R7: invalidate clears all; refill then goes to slot 0 (R6 first invalid)
        @(negedge clk); inval = 1'b1;
        @(negedge clk); inval = 1'b0;
        expect_miss_fill(20'h23, 8'd3, "R7", 0);
        expect_hit(20'h23, 8'd3, "R5");
        lookup(20'h30, 8'd3);
        chk(s_hit === 1'b0, "R7", "cleared entry misses", 32'(s_hit), 0);
        serve(20'h30, 8'd3, 0);

        // R8: invalidate in the response cycle drops the install
        expect_miss_fill(20'h40, 8'd5, "R2", 1);
        expect_miss_fill(20'h40, 8'd5, "R8", 0);
        expect_hit(20'h40, 8'd5, "R5");

        // R8: invalidate while pending drops the later response
        expect_miss_fill(20'h41, 8'd5, "R2", 2);
        expect_miss_fill(20'h41, 8'd5, "R8", 0);
        expect_hit(20'h41, 8'd5, "R5");

        // R9: stray response when idle installs nothing
        @(negedge clk); inval = 1'b1;
        @(negedge clk); inval = 1'b0;
        fill_valid = 1'b1; fill_pfn = mk_pfn(20'h41, 8'd5); fill_attr = mk_attr(20'h41, 8'd5);
        @(negedge clk); fill_valid = 1'b0;
        chk(fill_req === 1'b0, "R9", "no refill from stray response", 32'(fill_req), 0);
        expect_miss_fill(20'h41, 8'd5, "R9", 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: run did not complete actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule